// File: doc/BRIEF.md
# UART Receive Control-Character Filter

This block sits between a UART receiver's character assembler and the receive buffer logic. Each received character is compared with a table of up to eight programmable control characters. Every entry has its own compare mask. When a character matches, the entry's action bit selects one of two outcomes. The character can close the current message: it is stored and flagged as end-of-message. Or the character can be diverted: it is not stored, it is captured in a holding register, and a maskable interrupt is raised. Characters that match no entry pass to the buffer side unchanged.

The table is programmed through static configuration ports before reception starts. Typical uses are an end-of-line character that ends a message, and flow-control characters such as XON/XOFF. The software must see those, but they must never land in the data buffer. Characters that carry a framing or parity error skip the comparison and are passed on with their error flags.

Top module: `uart_ctl_filter`

## Requirements
- R1: A valid, error-free character that matches no table entry produces, on the first clock edge after it is sampled, `store_o`=1, `data_o` equal to the character, and `eom_o`=0.
- R2: A character matching an entry whose `tbl_rej_i` bit is 0 is stored with `store_o`=1 and `eom_o`=1 in the same cycle.
- R3: A character matching an entry whose `tbl_rej_i` bit is 1 gives `store_o`=0. The character is loaded into `rej_char_o`, and the pending flag is set.
- R4: `irq_o` is the pending flag gated by `irq_en_i`. A one-cycle pulse on `irq_clr_i` clears the pending flag unless a new reject arrives in that same cycle.
- R5: Entry i occupies bits [8i+7:8i] of `tbl_char_i` and `tbl_mask_i`. A character matches entry i when it equals the entry's value in every bit where the mask is 1. Bits where the mask is 0 are ignored.
- R6: The table ends at the first entry whose `tbl_valid_i` bit is 0. Entries after it never match, even if they are marked valid.
- R7: When several entries match, the lowest-numbered entry decides the action.
- R8: Each new reject overwrites `rej_char_o`. A reject that arrives while the pending flag is still set makes `ovr_o` go to 1. `ovr_o` stays at 1 until `irq_clr_i` is pulsed.
- R9: A character with `frm_err_i` or `par_err_i` set is not compared. It is stored with `eom_o`=0 and its error flag is copied to `frm_err_o`/`par_err_o`. The pending flag and `rej_char_o` are left unchanged.
- R10: After reset, `store_o`, `eom_o`, `irq_o`, `ovr_o` and `rej_char_o` are all 0.
- R11: In a cycle in which `chr_vld_i` is 0, no store strobe is produced on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_char_i | input | N_ENT*DW | Control-character values, entry i at [DW*i +: DW] |
| tbl_mask_i | input | N_ENT*DW | Per-entry compare mask, 1 = bit compared |
| tbl_valid_i | input | N_ENT | Entry valid bits; the table ends at the first 0 |
| tbl_rej_i | input | N_ENT | Entry action: 1 = reject to holding register, 0 = end of message |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clears pending flag and overwrite flag |
| chr_vld_i | input | 1 | Received-character strobe |
| chr_data_i | input | DW | Received character |
| frm_err_i | input | 1 | Framing error on this character |
| par_err_i | input | 1 | Parity error on this character |
| store_o | output | 1 | Character to be written to the buffer |
| data_o | output | DW | Character to store |
| eom_o | output | 1 | Stored character ends the message |
| frm_err_o | output | 1 | Framing error of the stored character |
| par_err_o | output | 1 | Parity error of the stored character |
| rej_char_o | output | DW | Last rejected control character |
| irq_o | output | 1 | Reject interrupt (pending and enabled) |
| ovr_o | output | 1 | Sticky: a reject overwrote an uncleared one |

## Verification
Plain characters are sent to show that they pass through untouched, and they are contrasted with exact matches of each action kind. This shows that the action bit, and not just the fact of a match, decides whether a character is stored or diverted. A masked entry is hit with a character that differs only in ignored bits, which separates masked compare from exact compare. A valid entry placed behind an invalid one, and two entries matching the same character with opposite actions, show that the table ends at the first gap and that priority goes to the lowest index. Reject characters sent with errors, and back-to-back rejects without a clear, separate the error bypass from normal compare and exercise the overwrite flag.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
  localparam int unsigned DW_DEF  = 8;
  localparam int unsigned ENT_DEF = 8;

  typedef enum logic {
    ACT_EOM = 1'b0,
    ACT_REJ = 1'b1
  } ucf_act_e;
endpackage

// File: rtl/ucf_match_table.sv
module ucf_match_table #(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_ENT = 8
) (
  input  logic [N_ENT*DW-1:0] tbl_char_i,
  input  logic [N_ENT*DW-1:0] tbl_mask_i,
  input  logic [N_ENT-1:0]    tbl_valid_i,
  input  logic [N_ENT-1:0]    tbl_rej_i,
  input  logic [DW-1:0]       chr_i,
  output logic                hit_o,
  output ucf_pkg::ucf_act_e   act_o
);
  logic [N_ENT-1:0] eq;
  logic [N_ENT-1:0] live;
  logic [N_ENT-1:0] hit_vec;

  // live[i]: entries 0..i are all valid
  assign live[0] = tbl_valid_i[0];
  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign eq[i] = ((chr_i ^ tbl_char_i[i*DW +: DW]) & tbl_mask_i[i*DW +: DW]) == '0;
      if (i > 0) begin : g_chain
        assign live[i] = live[i-1] & tbl_valid_i[i];
      end
    end
  endgenerate

  assign hit_vec = eq & live;
  assign hit_o   = |hit_vec;

  // lowest index wins: scan downward, last assignment stands
  always_comb begin
    act_o = ucf_pkg::ACT_EOM;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) act_o = tbl_rej_i[i] ? ucf_pkg::ACT_REJ : ucf_pkg::ACT_EOM;
    end
  end
endmodule

// File: rtl/ucf_reject_hold.sv
module ucf_reject_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rej_i,
  input  logic [DW-1:0] chr_i,
  input  logic          clr_i,
  output logic [DW-1:0] hold_o,
  output logic          pend_o,
  output logic          ovr_o
);
  logic [DW-1:0] hold_q;
  logic          pend_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rej_i) hold_q <= chr_i;
      // a new reject beats a clear in the same cycle
      if (rej_i)      pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
      if (clr_i)                ovr_q <= 1'b0;
      else if (rej_i && pend_q) ovr_q <= 1'b1;
    end
  end

  assign hold_o = hold_q;
  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/uart_ctl_filter.sv
module uart_ctl_filter #(
  parameter int unsigned DW    = ucf_pkg::DW_DEF,
  parameter int unsigned N_ENT = ucf_pkg::ENT_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_ENT*DW-1:0] tbl_char_i,
  input  logic [N_ENT*DW-1:0] tbl_mask_i,
  input  logic [N_ENT-1:0]    tbl_valid_i,
  input  logic [N_ENT-1:0]    tbl_rej_i,
  input  logic                irq_en_i,
  input  logic                irq_clr_i,
  input  logic                chr_vld_i,
  input  logic [DW-1:0]       chr_data_i,
  input  logic                frm_err_i,
  input  logic                par_err_i,
  output logic                store_o,
  output logic [DW-1:0]       data_o,
  output logic                eom_o,
  output logic                frm_err_o,
  output logic                par_err_o,
  output logic [DW-1:0]       rej_char_o,
  output logic                irq_o,
  output logic                ovr_o
);
  logic              cmp_en;
  logic              hit_w;
  ucf_pkg::ucf_act_e act_w;
  logic              rej_now;
  logic              eom_now;
  logic              pend_w;

  logic          store_q, eom_q, frm_q, par_q;
  logic [DW-1:0] data_q;

  // errored characters bypass the compare
  assign cmp_en  = chr_vld_i & ~frm_err_i & ~par_err_i;
  assign rej_now = cmp_en & hit_w & (act_w == ucf_pkg::ACT_REJ);
  assign eom_now = cmp_en & hit_w & (act_w == ucf_pkg::ACT_EOM);

  ucf_match_table #(.DW(DW), .N_ENT(N_ENT)) u_match (
    .tbl_char_i  (tbl_char_i),
    .tbl_mask_i  (tbl_mask_i),
    .tbl_valid_i (tbl_valid_i),
    .tbl_rej_i   (tbl_rej_i),
    .chr_i       (chr_data_i),
    .hit_o       (hit_w),
    .act_o       (act_w)
  );

  ucf_reject_hold #(.DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rej_i  (rej_now),
    .chr_i  (chr_data_i),
    .clr_i  (irq_clr_i),
    .hold_o (rej_char_o),
    .pend_o (pend_w),
    .ovr_o  (ovr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      eom_q   <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      store_q <= chr_vld_i & ~rej_now;
      eom_q   <= eom_now;
      frm_q   <= chr_vld_i & frm_err_i;
      par_q   <= chr_vld_i & par_err_i;
      if (chr_vld_i && !rej_now) data_q <= chr_data_i;
    end
  end

  assign store_o   = store_q;
  assign data_o    = data_q;
  assign eom_o     = eom_q;
  assign frm_err_o = frm_q;
  assign par_err_o = par_q;
  assign irq_o     = pend_w & irq_en_i;
endmodule

// File: rtl/ucf_chk.sv
module ucf_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chr_vld_i,
  input logic [DW-1:0] chr_data_i,
  input logic          frm_err_i,
  input logic          par_err_i,
  input logic          irq_clr_i,
  input logic          hit_i,
  input logic          rej_i,
  input logic          store_o,
  input logic          eom_o,
  input logic [DW-1:0] rej_char_o,
  input logic          irq_o,
  input logic          ovr_o
);
  // R2
  eom_implies_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_o |-> store_o);

  // R3
  reject_diverts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_vld_i && hit_i && rej_i && !frm_err_i && !par_err_i)
      |=> (!store_o && rej_char_o == $past(chr_data_i)));

  // R11
  idle_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chr_vld_i |=> !store_o);

  // R9
  err_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_vld_i && (frm_err_i || par_err_i)) |=> (store_o && !eom_o && $stable(rej_char_o)));

  // R4
  clear_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(chr_vld_i && hit_i && rej_i && !frm_err_i && !par_err_i)) |=> !irq_o);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !irq_clr_i) |=> ovr_o);
endmodule

bind uart_ctl_filter ucf_chk #(.DW(DW)) u_ucf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chr_vld_i  (chr_vld_i),
  .chr_data_i (chr_data_i),
  .frm_err_i  (frm_err_i),
  .par_err_i  (par_err_i),
  .irq_clr_i  (irq_clr_i),
  .hit_i      (hit_w),
  .rej_i      (act_w == ucf_pkg::ACT_REJ),
  .store_o    (store_o),
  .eom_o      (eom_o),
  .rej_char_o (rej_char_o),
  .irq_o      (irq_o),
  .ovr_o      (ovr_o)
);

// File: tb/tb_uart_ctl_filter.sv
module tb_uart_ctl_filter;
  localparam int DW = 8;
  localparam int NE = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NE*DW-1:0] tbl_char_i, tbl_mask_i;
  logic [NE-1:0] tbl_valid_i, tbl_rej_i;
  logic irq_en_i = 1'b0, irq_clr_i = 1'b0;
  logic chr_vld_i = 1'b0;
  logic [DW-1:0] chr_data_i = '0;
  logic frm_err_i = 1'b0, par_err_i = 1'b0;
  logic store_o, eom_o, frm_err_o, par_err_o, irq_o, ovr_o;
  logic [DW-1:0] data_o, rej_char_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  uart_ctl_filter #(.DW(DW), .N_ENT(NE)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input logic [7:0] c, input logic [7:0] m,
                         input logic v, input logic rej);
    tbl_char_i[i*DW +: DW] = c;
    tbl_mask_i[i*DW +: DW] = m;
    tbl_valid_i[i] = v;
    tbl_rej_i[i] = rej;
  endtask

  // drive one character for one edge; sample outputs at the following negedge
  task automatic send(input logic [7:0] c, input logic fe, input logic pe);
    @(negedge clk_i);
    chr_vld_i = 1'b1; chr_data_i = c; frm_err_i = fe; par_err_i = pe;
    @(negedge clk_i);
    chr_vld_i = 1'b0; frm_err_i = 1'b0; par_err_i = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "store", store_o, 0);
    chk("R10", "eom", eom_o, 0);
    chk("R10", "irq", irq_o, 0);
    chk("R10", "ovr", ovr_o, 0);
    chk("R10", "rej_char", rej_char_o, 0);
  endtask

  task automatic t_plain();
    send(8'h41, 0, 0);
    chk("R1", "store", store_o, 1);
    chk("R1", "data", data_o, 'h41);
    chk("R1", "eom", eom_o, 0);
    send(8'h7E, 0, 0);
    chk("R1", "data2", data_o, 'h7E);
  endtask

  task automatic t_eom();
    send(8'h0A, 0, 0);
    chk("R2", "store", store_o, 1);
    chk("R2", "eom", eom_o, 1);
    chk("R2", "data", data_o, 'h0A);
  endtask

  task automatic t_reject();
    irq_en_i = 1'b1;
    send(8'h11, 0, 0);
    chk("R3", "store", store_o, 0);
    chk("R3", "rej_char", rej_char_o, 'h11);
    chk("R4", "irq", irq_o, 1);
    irq_en_i = 1'b0; #1;
    chk("R4", "irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    clear_irq();
    chk("R4", "irq cleared", irq_o, 0);
    chk("R8", "no ovr", ovr_o, 0);
  endtask

  task automatic t_overwrite();
    send(8'h11, 0, 0);
    send(8'h13, 0, 0);
    chk("R8", "rej_char", rej_char_o, 'h13);
    chk("R8", "ovr", ovr_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R8", "ovr sticky", ovr_o, 1);
    clear_irq();
    chk("R8", "ovr cleared", ovr_o, 0);
  endtask

  task automatic t_mask();
    send(8'h37, 0, 0);
    chk("R5", "masked eom", eom_o, 1);
    send(8'h47, 0, 0);
    chk("R5", "outside mask", eom_o, 0);
  endtask

  task automatic t_chain();
    send(8'h55, 0, 0);
    chk("R6", "store", store_o, 1);
    chk("R6", "irq", irq_o, 0);
    chk("R6", "rej_char", rej_char_o, 'h13);
  endtask

  task automatic t_prio();
    set_ent(1, 8'h0A, 8'hFF, 1'b1, 1'b1);
    send(8'h0A, 0, 0);
    chk("R7", "eom", eom_o, 1);
    chk("R7", "irq", irq_o, 0);
    set_ent(0, 8'h0A, 8'hFF, 1'b1, 1'b1);
    set_ent(1, 8'h0A, 8'hFF, 1'b1, 1'b0);
    send(8'h0A, 0, 0);
    chk("R7", "reject first", store_o, 0);
    clear_irq();
    set_ent(0, 8'h0A, 8'hFF, 1'b1, 1'b0);
    set_ent(1, 8'h11, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_err();
    send(8'h11, 1, 0);
    chk("R9", "store", store_o, 1);
    chk("R9", "frm", frm_err_o, 1);
    chk("R9", "irq", irq_o, 0);
    send(8'h0A, 0, 1);
    chk("R9", "par", par_err_o, 1);
    chk("R9", "no eom", eom_o, 0);
    chk("R9", "rej_char kept", rej_char_o, 'h0A);
  endtask

  task automatic t_idle();
    repeat (2) @(negedge clk_i);
    chk("R11", "store", store_o, 0);
  endtask

  initial begin
    tbl_char_i = '0; tbl_mask_i = '0; tbl_valid_i = '0; tbl_rej_i = '0;
    set_ent(0, 8'h0A, 8'hFF, 1'b1, 1'b0);
    set_ent(1, 8'h11, 8'hFF, 1'b1, 1'b1);
    set_ent(2, 8'h13, 8'hFF, 1'b1, 1'b1);
    set_ent(3, 8'h30, 8'hF0, 1'b1, 1'b0);
    set_ent(4, 8'h00, 8'hFF, 1'b0, 1'b0);
    set_ent(5, 8'h55, 8'hFF, 1'b1, 1'b1);
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_plain();
    t_eom();
    t_reject();
    t_overwrite();
    t_mask();
    t_chain();
    t_prio();
    // reject 0x0A via entry0 above left rej_char at 0x0A
    t_err();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule